// File: doc/BRIEF.md
# Port Interrupt-on-Change Detector

This block watches two 8-bit input ports and raises one shared, sticky change flag whenever any pin that software has enabled changes level in either direction. Each pin has its own enable bit in a per-port mask. The inputs pass through a synchroniser. After that, each pin's level is compared with a reference copy that is refreshed on every clock.

A shared request enable decides whether a set flag turns into an interrupt request. A priority select steers that request to either the high-priority line or the low-priority line. The flag stays set until software pulses the clear input. A change that is detected in the same cycle as the clear wins over the clear, so no event is lost.

A pin whose enable bit changes is not compared in that cycle, so the act of unmasking or masking a pin cannot look like a change. Right after reset, comparison stays off until the synchroniser and the reference both hold real samples.

Top module: `port_change_detect`

## Requirements
- R1: While reset is high and in the cycle after it, `chg_flag`, `irq_hi` and `irq_lo` are 0.
- R2: A rising level on an enabled pin, applied before clock edge E, sets `chg_flag` at edge E+2. That is two synchroniser stages followed by one compare.
- R3: A falling level on an enabled pin sets `chg_flag` with the same timing as R2.
- R4: Pins of port 0 (`port_in[7:0]`) and port 1 (`port_in[15:8]`) all set the same single flag.
- R5: A change on a pin whose bit in `chg_mask` is 0 has no effect on `chg_flag`.
- R6: `chg_flag` stays set until `flag_clr` is sampled high. It then reads 0 one cycle later, provided no change is detected in that cycle.
- R7: When a change is detected in the same cycle that `flag_clr` is high, `chg_flag` stays 1.
- R8: `irq_hi` equals the previous cycle's `chg_flag & irq_en & prio_high`. `irq_lo` equals the previous cycle's `chg_flag & irq_en & ~prio_high`.
- R9: With `irq_en` at 0, neither request line rises, while `chg_flag` still sets.
- R10: A pin whose `chg_mask` bit differs from its value in the previous cycle is not compared in that cycle.
- R11: No change is detected in the first three cycles after reset is released (synchroniser depth plus one). A level already present at the inputs when reset is released therefore never sets the flag.
- R12: `irq_hi` and `irq_lo` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_in | input | 16 | Asynchronous pin levels, port 1 in the upper byte |
| chg_mask | input | 16 | Per-pin change enable, 1 = watched |
| irq_en | input | 1 | Shared request enable |
| prio_high | input | 1 | 1 routes the request to `irq_hi`, 0 to `irq_lo` |
| flag_clr | input | 1 | Single-cycle clear of the change flag |
| chg_flag | output | 1 | Sticky shared change flag |
| irq_hi | output | 1 | High-priority request |
| irq_lo | output | 1 | Low-priority request |

## Verification
The assertions assume that `flag_clr`, `irq_en` and `prio_high` are synchronous to `clk`. Only `port_in` is treated as asynchronous.

The bench drives every input on the falling edge, so each value is stable for a whole cycle at the rising edge. Pin changes are spaced so that the two-stage synchroniser delay is the only latency that matters.

Mask edits are timed so that they fall exactly in the compare cycle of a pending pin change, which exercises the suppression rule. Clears are placed on the cycle of a fresh detection to exercise the priority of set over clear.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int unsigned DEF_NPORT = 2;
  localparam int unsigned DEF_PW    = 8;
  localparam int unsigned DEF_SYNC  = 2;

  typedef struct packed {
    logic hi;
    logic lo;
  } req_pair_t;

  function automatic req_pair_t route_req(input logic active, input logic sel_hi);
    req_pair_t r;
    r.hi = active & sel_hi;
    r.lo = active & ~sel_hi;
    return r;
  endfunction
endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= '0;
        else     stg[k] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= '0;
        else     stg[k] <= stg[k-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pcd_compare.sv
module pcd_compare #(
  parameter int unsigned NPORT = 2,
  parameter int unsigned PW    = 8,
  parameter int unsigned SYNC  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPORT*PW-1:0] synced,
  input  logic [NPORT*PW-1:0] mask,
  output logic                any_hit
);
  localparam int unsigned W     = NPORT * PW;
  localparam int unsigned WARM  = SYNC + 1;
  localparam int unsigned CW    = $clog2(WARM + 1);

  logic [W-1:0]     ref_q;
  logic [W-1:0]     mask_q;
  logic [CW-1:0]    warm_cnt;
  logic             armed;
  logic [NPORT-1:0] port_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q    <= '0;
      mask_q   <= '0;
      warm_cnt <= '0;
    end else begin
      ref_q  <= synced;
      mask_q <= mask;
      if (!armed) warm_cnt <= warm_cnt + 1'b1;
    end
  end

  assign armed = (warm_cnt == CW'(WARM));

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [PW-1:0] diff;
    logic [PW-1:0] watch;
    assign diff  = synced[p*PW +: PW] ^ ref_q[p*PW +: PW];
    assign watch = mask[p*PW +: PW] & mask_q[p*PW +: PW];
    assign port_hit[p] = |(diff & watch);
  end

  assign any_hit = armed & (|port_hit);
endmodule

// File: rtl/pcd_flag_req.sv
module pcd_flag_req
  import pcd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr,
  input  logic irq_en,
  input  logic prio_high,
  output logic flag,
  output logic irq_hi,
  output logic irq_lo
);
  req_pair_t nxt_req;

  assign nxt_req = route_req(flag & irq_en, prio_high);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      irq_hi <= 1'b0;
      irq_lo <= 1'b0;
    end else begin
      flag   <= hit | (flag & ~clr);
      irq_hi <= nxt_req.hi;
      irq_lo <= nxt_req.lo;
    end
  end
endmodule

// File: rtl/port_change_detect.sv
module port_change_detect
  import pcd_pkg::*;
#(
  parameter int unsigned NPORT = DEF_NPORT,
  parameter int unsigned PW    = DEF_PW,
  parameter int unsigned SYNC  = DEF_SYNC
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPORT*PW-1:0] port_in,
  input  logic [NPORT*PW-1:0] chg_mask,
  input  logic                irq_en,
  input  logic                prio_high,
  input  logic                flag_clr,
  output logic                chg_flag,
  output logic                irq_hi,
  output logic                irq_lo
);
  localparam int unsigned W = NPORT * PW;

  logic [W-1:0] synced;
  logic         any_hit;

  pcd_sync #(.W(W), .STAGES(SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (port_in),
    .q   (synced)
  );

  pcd_compare #(.NPORT(NPORT), .PW(PW), .SYNC(SYNC)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .synced  (synced),
    .mask    (chg_mask),
    .any_hit (any_hit)
  );

  pcd_flag_req u_req (
    .clk       (clk),
    .rst       (rst),
    .hit       (any_hit),
    .clr       (flag_clr),
    .irq_en    (irq_en),
    .prio_high (prio_high),
    .flag      (chg_flag),
    .irq_hi    (irq_hi),
    .irq_lo    (irq_lo)
  );
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker (
  input logic clk,
  input logic rst,
  input logic any_hit,
  input logic flag_clr,
  input logic irq_en,
  input logic prio_high,
  input logic chg_flag,
  input logic irq_hi,
  input logic irq_lo
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!chg_flag && !irq_hi && !irq_lo));

  p_hit_sets_r2: assert property (@(posedge clk) disable iff (rst)
    any_hit |=> chg_flag);

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (chg_flag && !flag_clr) |=> chg_flag);

  p_clear_drops_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !any_hit) |=> !chg_flag);

  p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && any_hit) |=> chg_flag);

  p_route_hi_r8: assert property (@(posedge clk) disable iff (rst)
    (chg_flag && irq_en && prio_high) |=> irq_hi);

  p_route_lo_r8: assert property (@(posedge clk) disable iff (rst)
    (chg_flag && irq_en && !prio_high) |=> irq_lo);

  p_gated_r9: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> (!irq_hi && !irq_lo));

  p_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
    !(irq_hi && irq_lo));
endmodule

bind port_change_detect pcd_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .any_hit   (any_hit),
  .flag_clr  (flag_clr),
  .irq_en    (irq_en),
  .prio_high (prio_high),
  .chg_flag  (chg_flag),
  .irq_hi    (irq_hi),
  .irq_lo    (irq_lo)
);

// File: tb/tb_port_change_detect.sv
`timescale 1ns/1ps
module tb_port_change_detect;
  localparam int S = 2;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] port_in  = '0;
  logic [W-1:0] chg_mask = '0;
  logic         irq_en = 1'b0, prio_high = 1'b0, flag_clr = 1'b0;
  logic         chg_flag, irq_hi, irq_lo;

  int n_run = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  port_change_detect dut (
    .clk(clk), .rst(rst), .port_in(port_in), .chg_mask(chg_mask),
    .irq_en(irq_en), .prio_high(prio_high), .flag_clr(flag_clr),
    .chg_flag(chg_flag), .irq_hi(irq_hi), .irq_lo(irq_lo)
  );

  // behavioural reference: queue of sampled pin words, newest at front
  logic [W-1:0] hist[$];
  logic [W-1:0] m_mprev;
  int  m_edges;
  logic m_flag, m_hi, m_lo;

  always @(posedge clk) begin
    if (rst) begin
      hist.delete();
      m_edges = 0; m_flag = 0; m_hi = 0; m_lo = 0; m_mprev = '0;
    end else begin
      logic hit;
      hit = 0;
      if (m_edges >= S + 1)
        hit = |((hist[S-1] ^ hist[S]) & chg_mask & m_mprev);
      m_hi   = m_flag & irq_en & prio_high;
      m_lo   = m_flag & irq_en & ~prio_high;
      m_flag = hit | (m_flag & ~flag_clr);
      hist.push_front(port_in);
      if (hist.size() > S + 1) void'(hist.pop_back());
      m_mprev = chg_mask;
      m_edges++;
    end
  end

  task automatic check(string req, logic got, logic exp, string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, chg_flag, m_flag, "flag vs model");
      check("R8", irq_hi, m_hi, "irq_hi vs model");
      check("R8", irq_lo, m_lo, "irq_lo vs model");
      check("R12", irq_hi & irq_lo, 1'b0, "both lines high");
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0; cyc(1);
  endtask

  initial begin
    // R1 / R11: levels present while reset is released
    port_in = 16'h00F0; chg_mask = '1;
    cyc(3);
    check("R1", chg_flag | irq_hi | irq_lo, 1'b0, "outputs in reset");
    rst = 1'b0;
    cur_req = "R11";
    cyc(1);
    check("R1", chg_flag, 1'b0, "flag after reset");
    cyc(6);
    check("R11", chg_flag, 1'b0, "no detect at reset release");

    // R2 rising edge, exact latency
    cur_req = "R2";
    port_in[0] = 1'b1;           // applied before edge E
    cyc(2);                       // edges E, E+1 passed
    check("R2", chg_flag, 1'b0, "not yet set after two edges");
    cyc(1);                       // edge E+2
    check("R2", chg_flag, 1'b1, "set after compare");
    cyc(3);
    check("R6", chg_flag, 1'b1, "sticky");
    cur_req = "R6";
    clear_flag();
    check("R6", chg_flag, 1'b0, "cleared");

    // R3 falling edge
    cur_req = "R3";
    port_in[0] = 1'b0; cyc(5);
    check("R3", chg_flag, 1'b1, "falling edge sets");
    clear_flag();

    // R4 pin on upper port
    cur_req = "R4";
    port_in[12] = 1'b1; cyc(5);
    check("R4", chg_flag, 1'b1, "port 1 pin sets shared flag");
    clear_flag();

    // R5 masked pin ignored
    cur_req = "R5";
    chg_mask = 16'hFFF7; cyc(2);
    port_in[3] = ~port_in[3]; cyc(6);
    check("R5", chg_flag, 1'b0, "masked pin ignored");
    port_in[3] = ~port_in[3]; cyc(6);
    check("R5", chg_flag, 1'b0, "masked pin ignored back");

    // R10 mask turns on in the compare cycle of a pending change
    cur_req = "R10";
    port_in[3] = ~port_in[3];
    cyc(2);
    chg_mask = '1;
    cyc(5);
    check("R10", chg_flag, 1'b0, "mask change suppresses compare");

    // R7 clear coincides with a fresh detection
    cur_req = "R7";
    port_in[5] = ~port_in[5]; cyc(5);
    port_in[6] = ~port_in[6];
    cyc(2);
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    check("R7", chg_flag, 1'b1, "set wins over clear");
    cyc(1);

    // R8 routing
    cur_req = "R8";
    irq_en = 1'b1; prio_high = 1'b1; cyc(2);
    check("R8", irq_hi, 1'b1, "high line");
    check("R8", irq_lo, 1'b0, "low line idle");
    prio_high = 1'b0; cyc(2);
    check("R8", irq_lo, 1'b1, "low line");
    check("R8", irq_hi, 1'b0, "high line idle");

    // R9 request disabled
    cur_req = "R9";
    irq_en = 1'b0; clear_flag();
    port_in[9] = ~port_in[9]; cyc(6);
    check("R9", chg_flag, 1'b1, "flag sets while disabled");
    check("R9", irq_hi | irq_lo, 1'b0, "no request while disabled");
    clear_flag();

    // mixed random traffic, model compared every cycle
    cur_req = "R6";
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) port_in = port_in ^ (16'h1 << $urandom_range(0, 15));
      if ($urandom_range(0, 9) == 0) chg_mask = $urandom;
      irq_en    = $urandom_range(0, 1);
      prio_high = $urandom_range(0, 1);
      flag_clr  = ($urandom_range(0, 5) == 0);
      cyc(1);
    end
    flag_clr = 1'b0;
    cyc(2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule